// File: doc/BRIEF.md
# Parity-Protected Byte Controller Datapath

This block is the register-transfer datapath of a small 8-bit processor controller. A 16-bit address register drives the storage address. Reads from storage bring in a two-byte word, and each byte carries its own even-parity bit. A write sends out a two-byte word with freshly generated parity. A one-byte-plus-parity port connects the block to an I/O unit in each direction.

Inside the block, a 16-bit read data register (RDR) captures every storage read. The RDR then feeds four destinations:
- the address register, with all 16 bits;
- the 16-bit operation register, with all 16 bits;
- the storage data register, with one selected byte;
- the ALU operand register, with one selected byte.

The storage data register can also load from the I/O input and supplies the ALU's B operand. The ALU operand register supplies the A operand and drives the I/O output. The 8-bit ALU is combinational.

No microcode store sits inside the block. External strobes choose which transfer happens on each clock.

Addresses below 128 never reach external storage. They hit an internal register file of four 32-byte banks, and the current interrupt level picks the bank.

Top module: `ctl_datapath`

## Requirements
- R1: While `rst_n` is low, the following all become zero: `sto_addr`, `op_reg`, `io_out`, `par_err`, every internal register and every register-file byte.
- R2: Bus layout on both storage buses is lane 1 in bits [17:9] and lane 0 in bits [8:0]. Each lane holds its byte in its low 8 bits and the parity bit on top. A `rd_strobe` with `sto_addr` >= 128 raises `sto_rd_en` in that same cycle, and the RDR captures {lane1 byte, lane0 byte} at the clock edge.
- R3: `ld_sar` copies the RDR into the address register, and `ld_op` copies it into `op_reg`. `ld_alu` and `ld_sdr_rdr` copy one RDR byte: bits [15:8] when `byte_sel`=1, bits [7:0] when `byte_sel`=0.
- R4: `ld_sdr_io` loads the storage data register from `io_in[7:0]` and takes priority over `ld_sdr_rdr`. With no load strobe, `io_in` has no effect.
- R5: `io_out` is {parity, ALU operand register}, where the parity bit makes the nine bits hold an even number of ones.
- R6: `alu_fn` selects the ALU function on `alu_res` = f(A, B): 0 add, 1 subtract A-B, 2 AND, 3 OR, 4 XOR, 5 pass B. Codes 6 and 7 give zero.
- R7: `alu_carry` is the carry-out for add and the borrow for subtract, and 0 otherwise. `alu_zero` is 1 exactly when `alu_res` is zero.
- R8: `sto_wr_bus` carries `alu_res` in lane 1 and the storage data register in lane 0, each lane with even parity. A `wr_strobe` with `sto_addr` >= 128 raises `sto_wr_en`.
- R9: When `sto_addr` < 128, `sto_rd_en` and `sto_wr_en` stay low. Reads and writes go to the register file instead, using the word at `sto_addr[4:1]`, with the even byte in the high lane. Address bits [6:5] are ignored.
- R10: `level` picks one of four register banks. A register written at one level reads back as untouched data at another level.
- R11: A parity mismatch sets the sticky flag `par_err` until reset. A mismatch counts only on an external read (`rd_strobe` with `sto_addr` >= 128, either lane) or on an I/O byte loaded by `ld_sdr_io`. Bus values that are not sampled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| level | input | 2 | Current interrupt level, selects register bank |
| rd_strobe | input | 1 | Storage read into the RDR |
| wr_strobe | input | 1 | Storage write of the write word |
| ld_sar | input | 1 | RDR to address register |
| ld_op | input | 1 | RDR to operation register |
| ld_alu | input | 1 | Selected RDR byte to ALU operand register |
| ld_sdr_rdr | input | 1 | Selected RDR byte to storage data register |
| ld_sdr_io | input | 1 | I/O input byte to storage data register |
| byte_sel | input | 1 | RDR byte select, 1 = high byte |
| alu_fn | input | 3 | ALU function code |
| sto_rd_bus | input | 18 | Storage read data, two bytes with parity |
| io_in | input | 9 | Byte plus parity from the I/O unit |
| sto_addr | output | 16 | Storage address |
| sto_rd_en | output | 1 | External storage read qualifier |
| sto_wr_en | output | 1 | External storage write qualifier |
| sto_wr_bus | output | 18 | Storage write data, two bytes with parity |
| io_out | output | 9 | Byte plus parity to the I/O unit |
| op_reg | output | 16 | Operation register for the decoder |
| alu_res | output | 8 | ALU result |
| alu_carry | output | 1 | Carry or borrow |
| alu_zero | output | 1 | Result is zero |
| par_err | output | 1 | Sticky parity-error flag |

## Verification
The hardest state to reach is a chosen register-file word at a low address, because the address register loads only from the RDR, and after reset the address is 0, which itself lies in the register window. The stimulus first writes a crafted word into bank word 0: pass-B or the zero function sets the high lane, and the I/O-loaded data register sets the low lane. It then reads that word back and moves it into the address register, which puts the datapath at an address such as 0x0042. From there, writes and reads are replayed under other interrupt levels to show the banks are separate.

// File: rtl/dp_pkg.sv
// Package dp_pkg
// Shared ALU function codes and the even-parity helper used by every
// byte lane of the controller datapath.
package dp_pkg;

    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_AND   = 3'd2,
        ALU_OR    = 3'd3,
        ALU_XOR   = 3'd4,
        ALU_PASSB = 3'd5
    } alu_fn_e;

    // Parity bit that makes data plus parity hold an even count of ones.
    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/dp_par_gen.sv
// Module dp_par_gen
// Packs LANES bytes into a bus, each lane {parity, byte}, lane 0 lowest.
// Assumes 8-bit data lanes.
module dp_par_gen #(
    parameter int LANES = 2
) (
    input  logic [LANES*8-1:0] data,
    output logic [LANES*9-1:0] bus
);
    import dp_pkg::*;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Place byte and its generated parity into lane i.
        assign bus[i*9 +: 9] = {even_par(data[i*8 +: 8]), data[i*8 +: 8]};
    end

endmodule

// File: rtl/dp_par_chk.sv
// Module dp_par_chk
// Unpacks LANES {parity, byte} lanes and flags any lane whose nine bits
// hold an odd count of ones. Purely combinational.
module dp_par_chk #(
    parameter int LANES = 2
) (
    input  logic [LANES*9-1:0] bus,
    output logic [LANES*8-1:0] data,
    output logic               err
);
    logic [LANES-1:0] lane_err;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Strip the parity bit and check the lane.
        assign data[i*8 +: 8] = bus[i*9 +: 8];
        assign lane_err[i]    = ^bus[i*9 +: 9];
    end

    assign err = |lane_err;

endmodule

// File: rtl/dp_regfile.sv
// Module dp_regfile
// Banked register file: BANKS banks of WORDS two-byte words. One bank is
// selected by the interrupt level; asynchronous read, synchronous write.
// Assumes the caller qualifies wr_en with the register-window decode.
module dp_regfile #(
    parameter int BANKS = 4,
    parameter int WORDS = 16,
    localparam int BW   = $clog2(BANKS),
    localparam int WW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] bank_sel,
    input  logic [WW-1:0] word_sel,
    input  logic          wr_en,
    input  logic [15:0]   wr_word,
    output logic [15:0]   rd_word
);
    logic [15:0] bank_rd [BANKS];

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [15:0] mem [WORDS];

        // Clear on reset, otherwise write the addressed word of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) mem[w] <= '0;
            end else if (wr_en && (bank_sel == BW'(g))) begin
                mem[word_sel] <= wr_word;
            end
        end

        assign bank_rd[g] = mem[word_sel];
    end

    assign rd_word = bank_rd[bank_sel];

endmodule

// File: rtl/dp_alu.sv
// Module dp_alu
// 8-bit combinational ALU. Carry is carry-out for add, borrow for
// subtract, zero otherwise. Unused codes produce zero.
module dp_alu (
    input  logic [2:0] fn,
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] res,
    output logic       carry,
    output logic       zero
);
    import dp_pkg::*;

    logic [8:0] wide;

    // Compute a 9-bit result whose top bit is carry or borrow.
    always_comb begin
        case (alu_fn_e'(fn))
            ALU_ADD:   wide = {1'b0, a} + {1'b0, b};
            ALU_SUB:   wide = {1'b0, a} - {1'b0, b};
            ALU_AND:   wide = {1'b0, a & b};
            ALU_OR:    wide = {1'b0, a | b};
            ALU_XOR:   wide = {1'b0, a ^ b};
            ALU_PASSB: wide = {1'b0, b};
            default:   wide = '0;
        endcase
    end

    assign res   = wide[7:0];
    assign carry = wide[8];
    assign zero  = (wide[7:0] == 8'h00);

endmodule

// File: rtl/ctl_datapath.sv
// Module ctl_datapath
// Byte-oriented controller datapath. Strobes from an external sequencer
// select register transfers. Addresses below REG_SPACE go to a banked
// internal register file instead of storage. Parity is checked on sampled
// inputs and generated on outputs. Assumes one strobe per destination per
// cycle; ld_sdr_io wins over ld_sdr_rdr.
module ctl_datapath #(
    parameter int AW        = 16,
    parameter int REG_SPACE = 128,
    parameter int BANKS     = 4,
    localparam int LVL_W    = $clog2(BANKS),
    localparam int WORDS    = REG_SPACE / BANKS / 2,
    localparam int WW       = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic             rd_strobe,
    input  logic             wr_strobe,
    input  logic             ld_sar,
    input  logic             ld_op,
    input  logic             ld_alu,
    input  logic             ld_sdr_rdr,
    input  logic             ld_sdr_io,
    input  logic             byte_sel,
    input  logic [2:0]       alu_fn,
    input  logic [17:0]      sto_rd_bus,
    input  logic [8:0]       io_in,
    output logic [AW-1:0]    sto_addr,
    output logic             sto_rd_en,
    output logic             sto_wr_en,
    output logic [17:0]      sto_wr_bus,
    output logic [8:0]       io_out,
    output logic [15:0]      op_reg,
    output logic [7:0]       alu_res,
    output logic             alu_carry,
    output logic             alu_zero,
    output logic             par_err
);
    localparam logic [AW-1:0] REG_LIMIT = AW'(REG_SPACE);

    logic [AW-1:0] sar_q;
    logic [15:0]   rdr_q;
    logic [15:0]   op_q;
    logic [7:0]    sdr_q;
    logic [7:0]    alur_q;
    logic          perr_q;

    logic          in_window;
    logic [15:0]   ext_word;
    logic          ext_err;
    logic [7:0]    io_byte;
    logic          io_err;
    logic [15:0]   rf_word;
    logic [7:0]    rdr_byte;

    // Register-window decode and external qualifiers.
    assign in_window = (sar_q < REG_LIMIT);
    assign sto_rd_en = rd_strobe && !in_window;
    assign sto_wr_en = wr_strobe && !in_window;
    assign rdr_byte  = byte_sel ? rdr_q[15:8] : rdr_q[7:0];

    dp_par_chk #(.LANES(2)) u_rd_chk (
        .bus  (sto_rd_bus),
        .data (ext_word),
        .err  (ext_err)
    );

    dp_par_chk #(.LANES(1)) u_io_chk (
        .bus  (io_in),
        .data (io_byte),
        .err  (io_err)
    );

    dp_regfile #(.BANKS(BANKS), .WORDS(WORDS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_sel (level),
        .word_sel (sar_q[WW:1]),
        .wr_en    (wr_strobe && in_window),
        .wr_word  ({alu_res, sdr_q}),
        .rd_word  (rf_word)
    );

    dp_alu u_alu (
        .fn    (alu_fn),
        .a     (alur_q),
        .b     (sdr_q),
        .res   (alu_res),
        .carry (alu_carry),
        .zero  (alu_zero)
    );

    dp_par_gen #(.LANES(2)) u_wr_gen (
        .data ({alu_res, sdr_q}),
        .bus  (sto_wr_bus)
    );

    dp_par_gen #(.LANES(1)) u_io_gen (
        .data (alur_q),
        .bus  (io_out)
    );

    // Read data register: captures storage or register-file word.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdr_q <= '0;
        else if (rd_strobe) rdr_q <= in_window ? rf_word : ext_word;
    end

    // Address and operation registers load the whole RDR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar_q <= '0;
            op_q  <= '0;
        end else begin
            if (ld_sar) sar_q <= AW'(rdr_q);
            if (ld_op)  op_q  <= rdr_q;
        end
    end

    // Byte registers: storage data (I/O has priority) and ALU operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdr_q  <= '0;
            alur_q <= '0;
        end else begin
            if (ld_sdr_io)       sdr_q <= io_byte;
            else if (ld_sdr_rdr) sdr_q <= rdr_byte;
            if (ld_alu)          alur_q <= rdr_byte;
        end
    end

    // Sticky parity error on sampled inputs only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            perr_q <= 1'b0;
        else if ((sto_rd_en && ext_err) || (ld_sdr_io && io_err))
            perr_q <= 1'b1;
    end

    assign sto_addr = sar_q;
    assign op_reg   = op_q;
    assign par_err  = perr_q;

endmodule

// File: rtl/dp_checker.sv
// Module dp_checker
// Temporal checks on ctl_datapath, bound to every instance.
module dp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_strobe,
    input logic        wr_strobe,
    input logic        ld_sar,
    input logic [15:0] sto_addr,
    input logic        sto_rd_en,
    input logic        sto_wr_en,
    input logic [17:0] sto_wr_bus,
    input logic [8:0]  io_out,
    input logic [15:0] op_reg,
    input logic        par_err,
    input logic [15:0] rdr_q
);
    // R1: reset clears address, operation register and error flag
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (sto_addr == 16'h0 && op_reg == 16'h0 && !par_err));

    // R3: address register takes the prior RDR value
    a_r3_sar_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_sar |=> (sto_addr == $past(rdr_q)));

    // R9: no external access inside the register window
    a_r9_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sto_addr < 16'd128) |-> (!sto_rd_en && !sto_wr_en));

    // R2: external read qualifier follows the strobe outside the window
    a_r2_ext_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && sto_addr >= 16'd128) |-> sto_rd_en);

    // R8: external write qualifier follows the strobe outside the window
    a_r8_ext_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && sto_addr >= 16'd128) |-> sto_wr_en);

    // R8: both write lanes leave with even parity
    a_r8_wr_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (^sto_wr_bus[17:9] == 1'b0) && (^sto_wr_bus[8:0] == 1'b0));

    // R5: I/O output byte leaves with even parity
    a_r5_io_parity: assert property (@(posedge clk) disable iff (!rst_n)
        ^io_out == 1'b0);

    // R11: the error flag never clears outside reset
    a_r11_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> par_err);

endmodule

bind ctl_datapath dp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .ld_sar     (ld_sar),
    .sto_addr   (sto_addr),
    .sto_rd_en  (sto_rd_en),
    .sto_wr_en  (sto_wr_en),
    .sto_wr_bus (sto_wr_bus),
    .io_out     (io_out),
    .op_reg     (op_reg),
    .par_err    (par_err),
    .rdr_q      (rdr_q)
);

// File: tb/ctl_datapath_bench.sv
// Scoreboard bench for ctl_datapath: the driver pushes expected values,
// the monitor pops and compares them on the falling clock edge.
module ctl_datapath_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  level;
    logic        rd_strobe, wr_strobe, ld_sar, ld_op, ld_alu;
    logic        ld_sdr_rdr, ld_sdr_io, byte_sel;
    logic [2:0]  alu_fn;
    logic [17:0] sto_rd_bus;
    logic [8:0]  io_in;
    logic [15:0] sto_addr;
    logic        sto_rd_en, sto_wr_en;
    logic [17:0] sto_wr_bus;
    logic [8:0]  io_out;
    logic [15:0] op_reg;
    logic [7:0]  alu_res;
    logic        alu_carry, alu_zero, par_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        string       req;
        int          kind;
        logic [17:0] exp;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    ctl_datapath u_ctl_datapath (
        .clk(clk), .rst_n(rst_n), .level(level),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .ld_sar(ld_sar), .ld_op(ld_op), .ld_alu(ld_alu),
        .ld_sdr_rdr(ld_sdr_rdr), .ld_sdr_io(ld_sdr_io),
        .byte_sel(byte_sel), .alu_fn(alu_fn),
        .sto_rd_bus(sto_rd_bus), .io_in(io_in),
        .sto_addr(sto_addr), .sto_rd_en(sto_rd_en), .sto_wr_en(sto_wr_en),
        .sto_wr_bus(sto_wr_bus), .io_out(io_out), .op_reg(op_reg),
        .alu_res(alu_res), .alu_carry(alu_carry), .alu_zero(alu_zero),
        .par_err(par_err)
    );

    localparam int K_ADDR = 0, K_OP = 1, K_IO = 2, K_RES = 3, K_CY = 4;
    localparam int K_ZERO = 5, K_WBUS = 6, K_WEN = 7, K_REN = 8, K_PERR = 9;

    function automatic logic [8:0] lane(input logic [7:0] b);
        return {^b, b};
    endfunction

    function automatic logic [17:0] word(input logic [7:0] h, input logic [7:0] l);
        return {lane(h), lane(l)};
    endfunction

    function automatic logic [17:0] observe(input int kind);
        case (kind)
            K_ADDR:  return 18'(sto_addr);
            K_OP:    return 18'(op_reg);
            K_IO:    return 18'(io_out);
            K_RES:   return 18'(alu_res);
            K_CY:    return 18'(alu_carry);
            K_ZERO:  return 18'(alu_zero);
            K_WBUS:  return sto_wr_bus;
            K_WEN:   return 18'(sto_wr_en);
            K_REN:   return 18'(sto_rd_en);
            default: return 18'(par_err);
        endcase
    endfunction

    // Monitor: compare queued expectations on the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [17:0] got;
            it  = sb.pop_front();
            got = observe(it.kind);
            checks++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s kind %0d: actual %h expected %h",
                         it.req, it.kind, got, it.exp);
            end
        end
    end

    task automatic expect_v(input string req, input int kind, input logic [17:0] v);
        item_t it;
        it.req = req; it.kind = kind; it.exp = v;
        sb.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        rd_strobe = 0; wr_strobe = 0; ld_sar = 0; ld_op = 0;
        ld_alu = 0; ld_sdr_rdr = 0; ld_sdr_io = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic alu_check(input string req, input logic [2:0] fn,
                             input logic [7:0] r, input logic c);
        alu_fn = fn;
        expect_v(req, K_RES, 18'(r));
        expect_v(req, K_CY, 18'(c));
        expect_v(req, K_ZERO, 18'(r == 8'h00));
        settle();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; level = 0; rd_strobe = 0; wr_strobe = 0; ld_sar = 0;
        ld_op = 0; ld_alu = 0; ld_sdr_rdr = 0; ld_sdr_io = 0; byte_sel = 0;
        alu_fn = 3'd5; sto_rd_bus = '0; io_in = '0;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        expect_v("R1", K_ADDR, 0); expect_v("R1", K_OP, 0);
        expect_v("R1", K_IO, 0);   expect_v("R1", K_PERR, 0);
        settle();
        rst_n = 1;
        tick();

        // R9 write and read the register window at address 0, level 0
        io_in = lane(8'h81); ld_sdr_io = 1; tick();
        alu_fn = 3'd5; wr_strobe = 1;
        expect_v("R9", K_WEN, 0);
        expect_v("R8", K_WBUS, word(8'h81, 8'h81));
        settle(); tick();
        rd_strobe = 1; expect_v("R9", K_REN, 0); settle(); tick();
        ld_op = 1; tick(); expect_v("R9", K_OP, 18'h8181);
        ld_sar = 1; tick(); expect_v("R3", K_ADDR, 18'h8181);

        // R2 external read
        sto_rd_bus = word(8'hA5, 8'h3C); rd_strobe = 1;
        expect_v("R2", K_REN, 1); settle(); tick();
        ld_op = 1; tick(); expect_v("R2", K_OP, 18'hA53C);
        expect_v("R11", K_PERR, 0);
        byte_sel = 1; ld_alu = 1; tick();
        expect_v("R5", K_IO, 18'(lane(8'hA5)));
        byte_sel = 0; ld_sdr_rdr = 1; tick();

        // R6 functions with A=A5, B=3C
        alu_check("R6", 3'd0, 8'hE1, 0);
        alu_check("R6", 3'd1, 8'h69, 0);
        alu_check("R6", 3'd2, 8'h24, 0);
        alu_check("R6", 3'd3, 8'hBD, 0);
        alu_check("R6", 3'd4, 8'h99, 0);
        alu_check("R6", 3'd5, 8'h3C, 0);
        alu_check("R6", 3'd6, 8'h00, 0);

        // R7 carry and borrow with F0 and 10
        sto_rd_bus = word(8'hF0, 8'h10); rd_strobe = 1; tick();
        byte_sel = 1; ld_alu = 1; tick();
        expect_v("R5", K_IO, 18'(lane(8'hF0)));
        byte_sel = 0; ld_sdr_rdr = 1; tick();
        alu_check("R7", 3'd0, 8'h00, 1);
        byte_sel = 0; ld_alu = 1; tick();
        expect_v("R5", K_IO, 18'(lane(8'h10)));
        byte_sel = 1; ld_sdr_rdr = 1; tick();
        alu_check("R7", 3'd1, 8'h20, 1);

        // R8 external write: XOR of 10 and F0 in lane 1, F0 in lane 0
        alu_fn = 3'd4; wr_strobe = 1;
        expect_v("R8", K_WEN, 1);
        expect_v("R8", K_WBUS, word(8'hE0, 8'hF0));
        settle(); tick();

        // R4 priority of I/O load, then an unloaded I/O byte has no effect
        io_in = lane(8'h5A); ld_sdr_io = 1; byte_sel = 0; ld_sdr_rdr = 1; tick();
        alu_check("R4", 3'd5, 8'h5A, 0);
        io_in = {1'b1, 8'h5A}; tick();
        alu_check("R4", 3'd5, 8'h5A, 0);
        expect_v("R11", K_PERR, 0); settle();

        // R11 bad read parity is sticky
        sto_rd_bus = {1'b1, 8'h12, 1'b0, 8'h34}; rd_strobe = 1; tick();
        expect_v("R11", K_PERR, 1);
        sto_rd_bus = word(8'h12, 8'h34); rd_strobe = 1; tick();
        expect_v("R11", K_PERR, 1);

        // R1 reset in mid-run
        rst_n = 0; tick(); tick();
        expect_v("R1", K_ADDR, 0); expect_v("R1", K_OP, 0);
        expect_v("R1", K_IO, 0);   expect_v("R1", K_PERR, 0);
        settle();
        rst_n = 1; tick();

        // R11 internal read ignores bus parity; bad loaded I/O byte sets it
        sto_rd_bus = {1'b1, 8'h00, 1'b1, 8'h00}; rd_strobe = 1; tick();
        expect_v("R11", K_PERR, 0);
        io_in = {1'b1, 8'h5A}; ld_sdr_io = 1; tick();
        expect_v("R11", K_PERR, 1);
        tick(); expect_v("R11", K_PERR, 1);
        rst_n = 0; tick(); rst_n = 1; tick();

        // R10 bank separation
        level = 0; io_in = lane(8'h05); ld_sdr_io = 1; tick();
        alu_fn = 3'd5; wr_strobe = 1; tick();
        rd_strobe = 1; tick(); ld_op = 1; tick();
        expect_v("R10", K_OP, 18'h0505);
        level = 1; rd_strobe = 1; tick(); ld_op = 1; tick();
        expect_v("R10", K_OP, 18'h0000);

        // R9 move to address 0x0042 through the level-1 bank
        io_in = lane(8'h42); ld_sdr_io = 1; tick();
        alu_fn = 3'd6; wr_strobe = 1; tick();
        rd_strobe = 1; tick(); ld_sar = 1; tick();
        expect_v("R9", K_ADDR, 18'h0042);
        io_in = lane(8'h77); ld_sdr_io = 1; tick();
        alu_fn = 3'd5; wr_strobe = 1;
        expect_v("R9", K_WEN, 0); settle(); tick();
        rd_strobe = 1; tick(); ld_op = 1; tick();
        expect_v("R9", K_OP, 18'h7777);
        level = 2; rd_strobe = 1; tick(); ld_op = 1; tick();
        expect_v("R10", K_OP, 18'h0000);
        level = 1; rd_strobe = 1; tick(); ld_op = 1; tick();
        expect_v("R10", K_OP, 18'h7777);

        settle();
        wait (sb.size() == 0);
        settle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule